// File: doc/BRIEF.md
# DDR2 Per-Bank Precharge and Activate Timing Guard

This block watches the command bus of a DDR2 memory controller and keeps a small timing model of every bank. Each clock it tells the scheduler, bank by bank, whether a Precharge or an Activate placed on the bus in that cycle would meet the device's spacing rules. It also keeps a sticky violation flag that records any command issued too early, or issued against a bank state that cannot accept it. It guards only the bank-level row timing. It drives no data, strobes or refresh.

The scheduler presents one command per cycle as a code and a bank number. Static configuration supplies the additive latency, the CAS latency, the burst length and the analog timings as whole clock counts, each rounded up by the integrator. Read latency is the sum of the additive and CAS latencies, and write latency is one clock less than read latency. The block has no data stream. Its command input has no valid/ready pair and no back-pressure. The outputs are advisory: a command is always taken into the model, legal or not, and an illegal one also raises the violation flag. The configuration must only change while reset is held.

Top module: `ddr2_bank_timing_guard`

## Requirements
- R1: After reset every bank is idle, `pre_ok` and `act_ok` are high for all banks (with a legal burst length) and `violation` is low.
- R2: Write latency is taken as AL + CL − 1 clocks, where read latency is AL + CL.
- R3: After a Read to an open bank at cycle t, with tRTP of two clocks or less, a Precharge to that bank becomes allowed at cycle t + AL + BL/2 and not before.
- R4: With BL = 8 and tRTP above two clocks, the Read-to-Precharge spacing grows by one clock to AL + BL/2 + 1. With BL = 4 it stays AL + BL/2.
- R5: After a Write to an open bank at cycle t, a Precharge becomes allowed at t + WL + BL/2 + tWR, so that write recovery counts from the last data beat.
- R6: A Precharge to a bank is allowed no earlier than tRAS cycles after that bank's Activate.
- R7: An Activate is allowed no earlier than tRP cycles after the bank's Precharge and no earlier than tRC cycles after its previous Activate, and only while the bank is idle.
- R8: A later command never shortens a pending wait: each counter keeps the larger of its remaining count and the new spacing.
- R9: A Precharge issued while `pre_ok` of its bank is low, or an Activate issued while `act_ok` is low, sets `violation`, which stays high until reset.
- R10: A Read or Write to an idle bank sets `violation`.
- R11: A Precharge to an idle bank is a no-op: it raises no violation and leaves the bank's Activate permission as it was.
- R12: Banks are independent: commands to one bank do not change the flags of another.
- R13: A burst length other than 4 or 8 holds every `pre_ok` and `act_ok` bit low.
- R14: Command codes on `cmd_code`: 0 NOP, 1 Activate, 2 Read, 3 Write, 4 Precharge. Codes 5 to 7 act as NOP. The flags reflect the cycle in which a command is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_bl | input | 4 | Burst length (4 or 8) |
| cfg_twr | input | CFG_W | Write recovery in clocks |
| cfg_rtp | input | CFG_W | Read-to-precharge time in clocks |
| cfg_ras | input | CFG_W | Activate-to-precharge minimum in clocks |
| cfg_rp | input | CFG_W | Precharge-to-activate minimum in clocks |
| cfg_rc | input | CFG_W | Activate-to-activate minimum in clocks |
| cmd_code | input | 3 | Command presented this cycle |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| pre_ok | output | NUM_BANKS | Per-bank: a Precharge this cycle is legal |
| act_ok | output | NUM_BANKS | Per-bank: an Activate this cycle is legal |
| violation | output | 1 | Sticky: an illegal command has been seen |

## Verification
The bench probes each spacing exactly one cycle before and at the first legal cycle. An off-by-one in the counter reload would open the window one clock early or hold it one clock late. It checks the extra clock for the eight-beat burst with a long tRTP, and confirms that a four-beat burst does not get it; a design that applied it everywhere would fail that case. It sends a short Read right after a long tRAS wait, which catches a counter that overwrites instead of keeping the maximum. It also sends a Precharge to an idle bank, which a careless design would flag or use to reload its Activate timer. Finally it checks that an early Precharge leaves the violation flag set through later quiet cycles, which a level-only flag would drop.

// File: rtl/ddr2_tg_pkg.sv
package ddr2_tg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

endpackage

// File: rtl/ddr2_tg_spacing.sv
module ddr2_tg_spacing #(
  parameter int CFG_W = 6,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic [2:0]       al,
  input  logic [2:0]       cl,
  input  logic [3:0]       bl,
  input  logic [CFG_W-1:0] twr,
  input  logic [CFG_W-1:0] rtp,
  output logic [CNT_W-1:0] rd_gap,
  output logic [CNT_W-1:0] wr_gap,
  output logic             bl_ok
);

  logic [CNT_W-1:0] al_w, cl_w, half_bl, rl_w, wl_w, twr_w;
  logic             extra_prefetch;

  always_comb begin
    al_w    = CNT_W'(al);
    cl_w    = CNT_W'(cl);
    twr_w   = CNT_W'(twr);
    half_bl = CNT_W'(bl >> 1);
    bl_ok   = (bl == 4'd4) || (bl == 4'd8);
    rl_w    = al_w + cl_w;
    // R2: write latency one below read latency, floored at zero
    wl_w    = (rl_w == '0) ? '0 : rl_w - 1'b1;
    // R4: eight-beat burst served as two prefetches costs a clock when tRTP is long
    extra_prefetch = (bl == 4'd8) && (rtp > CFG_W'(2));
    rd_gap  = al_w + half_bl + CNT_W'(extra_prefetch);
    // R5: recovery starts after the last write beat
    wr_gap  = wl_w + half_bl + twr_w;
  end

endmodule

// File: rtl/ddr2_tg_bank.sv
module ddr2_tg_bank
  import ddr2_tg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  dram_cmd_e        cmd,
  input  logic             bl_ok,
  input  logic [CNT_W-1:0] rd_gap,
  input  logic [CNT_W-1:0] wr_gap,
  input  logic [CNT_W-1:0] ras_gap,
  input  logic [CNT_W-1:0] rp_gap,
  input  logic [CNT_W-1:0] rc_gap,
  output logic             pre_ok,
  output logic             act_ok,
  output logic             bad_cmd
);

  logic             open_q;
  logic [CNT_W-1:0] pre_cnt, act_cnt;
  logic [CNT_W-1:0] pre_dec, act_dec;

  // keep the larger of the remaining wait and the new spacing (R8)
  function automatic logic [CNT_W-1:0] widen(input logic [CNT_W-1:0] dec,
                                             input logic [CNT_W-1:0] gap);
    logic [CNT_W-1:0] want;
    want = (gap == '0) ? '0 : gap - 1'b1;
    return (want > dec) ? want : dec;
  endfunction

  always_comb begin
    pre_dec = (pre_cnt == '0) ? '0 : pre_cnt - 1'b1;
    act_dec = (act_cnt == '0) ? '0 : act_cnt - 1'b1;
    // R11: an idle bank accepts a Precharge as a no-op
    pre_ok  = bl_ok && (!open_q || (pre_cnt == '0));
    act_ok  = bl_ok && !open_q && (act_cnt == '0);
    bad_cmd = sel && (((cmd == CMD_ACT) && !act_ok) ||
                      ((cmd == CMD_PRE) && !pre_ok) ||
                      (((cmd == CMD_RD) || (cmd == CMD_WR)) && !open_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      pre_cnt <= '0;
      act_cnt <= '0;
    end else begin
      pre_cnt <= pre_dec;
      act_cnt <= act_dec;
      if (sel) begin
        unique case (cmd)
          CMD_ACT: begin
            open_q  <= 1'b1;
            pre_cnt <= widen(pre_dec, ras_gap);
            act_cnt <= widen(act_dec, rc_gap);
          end
          CMD_RD:  if (open_q) pre_cnt <= widen(pre_dec, rd_gap);
          CMD_WR:  if (open_q) pre_cnt <= widen(pre_dec, wr_gap);
          CMD_PRE: if (open_q) begin
            open_q  <= 1'b0;
            act_cnt <= widen(act_dec, rp_gap);
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_ras_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == CMD_ACT && ras_gap > 1) |=> !pre_ok);

  a_r3_read_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == CMD_RD && open_q && rd_gap > 1) |=> !pre_ok);

  a_r5_write_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == CMD_WR && open_q && wr_gap > 1) |=> !pre_ok);

  a_r7_rp_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == CMD_PRE && open_q && rp_gap > 1) |=> !act_ok);

  a_r8_wait_never_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != '0) |=> (pre_cnt >= $past(pre_cnt) - 1'b1));

endmodule

// File: rtl/ddr2_bank_timing_guard.sv
module ddr2_bank_timing_guard
  import ddr2_tg_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  parameter  int CFG_W     = 6,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cfg_al,
  input  logic [2:0]           cfg_cl,
  input  logic [3:0]           cfg_bl,
  input  logic [CFG_W-1:0]     cfg_twr,
  input  logic [CFG_W-1:0]     cfg_rtp,
  input  logic [CFG_W-1:0]     cfg_ras,
  input  logic [CFG_W-1:0]     cfg_rp,
  input  logic [CFG_W-1:0]     cfg_rc,
  input  logic [2:0]           cmd_code,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic                 violation
);

  localparam int CNT_W = CFG_W + 2;

  dram_cmd_e              cmd_e;
  logic [CNT_W-1:0]       rd_gap, wr_gap;
  logic                   bl_ok;
  logic [NUM_BANKS-1:0]   bad_bank;
  logic                   bad_any;

  // R14: codes 5..7 fall through every case as a NOP
  assign cmd_e   = dram_cmd_e'(cmd_code);
  assign bad_any = |bad_bank;

  ddr2_tg_spacing #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_spacing (
    .al     (cfg_al),
    .cl     (cfg_cl),
    .bl     (cfg_bl),
    .twr    (cfg_twr),
    .rtp    (cfg_rtp),
    .rd_gap (rd_gap),
    .wr_gap (wr_gap),
    .bl_ok  (bl_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr2_tg_bank #(.CNT_W(CNT_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (cmd_bank == BANK_W'(b)),
      .cmd     (cmd_e),
      .bl_ok   (bl_ok),
      .rd_gap  (rd_gap),
      .wr_gap  (wr_gap),
      .ras_gap (CNT_W'(cfg_ras)),
      .rp_gap  (CNT_W'(cfg_rp)),
      .rc_gap  (CNT_W'(cfg_rc)),
      .pre_ok  (pre_ok[b]),
      .act_ok  (act_ok[b]),
      .bad_cmd (bad_bank[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) violation <= 1'b0;
    else if (bad_any) violation <= 1'b1;
  end

  a_r9_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  a_r10_bad_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    bad_any |=> violation);

  a_r13_bad_burst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !((cfg_bl == 4'd4) || (cfg_bl == 4'd8)) |-> (pre_ok == '0 && act_ok == '0));

  a_r12_one_bank_at_most: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bad_bank));

endmodule

// File: tb/test_ddr2_bank_timing_guard.sv
module test_ddr2_bank_timing_guard;

  localparam int NB = 8;
  localparam int CW = 6;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cfg_al, cfg_cl;
  logic [3:0]    cfg_bl;
  logic [CW-1:0] cfg_twr, cfg_rtp, cfg_ras, cfg_rp, cfg_rc;
  logic [2:0]    cmd_code;
  logic [2:0]    cmd_bank;
  logic [NB-1:0] pre_ok, act_ok;
  logic          violation;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr2_bank_timing_guard #(.NUM_BANKS(NB), .CFG_W(CW)) i_ddr2_bank_timing_guard (
    .clk(clk), .rst_n(rst_n),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .cfg_twr(cfg_twr), .cfg_rtp(cfg_rtp), .cfg_ras(cfg_ras),
    .cfg_rp(cfg_rp), .cfg_rc(cfg_rc),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .pre_ok(pre_ok), .act_ok(act_ok), .violation(violation)
  );

  // {cmd, bank, expected pre_ok[0], expected act_ok[0], expected violation}
  // Config: AL=2 CL=4 BL=4 tWR=3 tRTP=2 tRAS=6 tRP=3 tRC=9
  localparam int NV = 23;
  localparam logic [8:0] VEC [NV] = '{
    {ACT, 3'd0, 3'b110},  // t0  R1 idle bank
    {NOP, 3'd0, 3'b000},  // t1  R6 tRAS pending
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {RD,  3'd0, 3'b000},  // t4  R3 read: precharge at t8
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},  // t6  R8 tRAS met but read still pending
    {NOP, 3'd0, 3'b000},  // t7  R3 one cycle early
    {PRE, 3'd0, 3'b100},  // t8  R3 first legal precharge
    {NOP, 3'd0, 3'b100},  // t9  R7 tRP pending
    {NOP, 3'd0, 3'b100},
    {ACT, 3'd0, 3'b110},  // t11 R7 tRP met
    {WR,  3'd0, 3'b000},  // t12 R2 R5 write: WL=5, precharge at t22
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},
    {NOP, 3'd0, 3'b000},  // t21 R5 one cycle early
    {PRE, 3'd0, 3'b100}   // t22 R5 first legal precharge
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] bl, input logic [CW-1:0] rtp,
                         input logic [CW-1:0] ras, input logic [CW-1:0] rp,
                         input logic [CW-1:0] rc);
    cfg_al = 3'd2; cfg_cl = 3'd4; cfg_twr = 6'd3;
    cfg_bl = bl; cfg_rtp = rtp; cfg_ras = ras; cfg_rp = rp; cfg_rc = rc;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; cmd_code = NOP; cmd_bank = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present a command in the current cycle, return at the next negedge
  task automatic issue(input logic [2:0] c, input logic [2:0] b);
    cmd_code = c; cmd_bank = b;
    @(negedge clk);
    cmd_code = NOP;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Activate then Read bank 1 at t1; precharge first legal at t1+gap
  task automatic rd_probe(input logic [3:0] bl, input logic [CW-1:0] rtp,
                          input int gap, input string tag);
    set_cfg(bl, rtp, 6'd1, 6'd1, 6'd1);
    do_reset();
    issue(ACT, 3'd1);
    issue(RD, 3'd1);
    wait_cyc(gap - 2);
    chk(pre_ok[1], 0, {tag, " one cycle before read spacing"});
    wait_cyc(1);
    chk(pre_ok[1], 1, {tag, " at read spacing"});
    chk(violation, 0, {tag, " no violation"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R14 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    set_cfg(4'd4, 6'd2, 6'd6, 6'd3, 6'd9);
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk(pre_ok, 8'hFF, "R1 pre_ok after reset");
    chk(act_ok, 8'hFF, "R1 act_ok after reset");
    chk(violation, 0, "R1 violation after reset");

    // table walk: R2 R3 R5 R6 R7 R8 R14 on bank 0
    for (int i = 0; i < NV; i++) begin
      chk(pre_ok[0], VEC[i][2], $sformatf("R3/R5/R6 table row %0d pre_ok", i));
      chk(act_ok[0], VEC[i][1], $sformatf("R7 table row %0d act_ok", i));
      chk(violation, VEC[i][0], $sformatf("R9 table row %0d violation", i));
      issue(VEC[i][8:6], VEC[i][5:3]);
    end

    // R4 extra clock only for BL=8 with long tRTP (AL=2)
    rd_probe(4'd8, 6'd3, 7, "R4 BL8 long tRTP");
    rd_probe(4'd8, 6'd2, 6, "R3 BL8 short tRTP");
    rd_probe(4'd4, 6'd3, 4, "R4 BL4 long tRTP");

    // R8 short read after long tRAS does not shorten the wait
    set_cfg(4'd4, 6'd2, 6'd10, 6'd3, 6'd12);
    do_reset();
    issue(ACT, 3'd6);
    issue(RD, 3'd6);
    wait_cyc(7);
    chk(pre_ok[6], 0, "R8 tRAS still pending at t9");
    wait_cyc(1);
    chk(pre_ok[6], 1, "R8 tRAS met at t10");

    // R7 tRC governs Activate after a quick Precharge
    set_cfg(4'd4, 6'd2, 6'd1, 6'd1, 6'd9);
    do_reset();
    issue(ACT, 3'd7);
    chk(pre_ok[7], 1, "R6 tRAS=1 allows precharge next cycle");
    issue(PRE, 3'd7);
    wait_cyc(6);
    chk(act_ok[7], 0, "R7 tRC pending at t8");
    wait_cyc(1);
    chk(act_ok[7], 1, "R7 tRC met at t9");
    chk(violation, 0, "R7 legal sequence no violation");

    // R9 early precharge is flagged and sticks
    set_cfg(4'd4, 6'd2, 6'd6, 6'd3, 6'd9);
    do_reset();
    issue(ACT, 3'd3);
    issue(PRE, 3'd3);
    chk(violation, 1, "R9 early precharge flagged");
    wait_cyc(5);
    chk(violation, 1, "R9 violation sticky");

    // R9 Activate to an open bank
    do_reset();
    issue(ACT, 3'd2);
    wait_cyc(12);
    chk(violation, 0, "R9 no violation before second activate");
    issue(ACT, 3'd2);
    chk(violation, 1, "R9 activate to open bank flagged");

    // R10 write to idle bank
    do_reset();
    issue(WR, 3'd5);
    chk(violation, 1, "R10 write to idle bank flagged");
    do_reset();
    issue(RD, 3'd4);
    chk(violation, 1, "R10 read to idle bank flagged");

    // R11 precharge to idle bank is a no-op
    do_reset();
    issue(PRE, 3'd4);
    chk(violation, 0, "R11 idle precharge no violation");
    chk(act_ok[4], 1, "R11 idle precharge leaves activate allowed");

    // R12 bank independence
    do_reset();
    issue(ACT, 3'd2);
    chk(act_ok[2], 0, "R12 activated bank blocked");
    chk(act_ok[3], 1, "R12 neighbour activate unaffected");
    chk(pre_ok[3], 1, "R12 neighbour precharge unaffected");

    // R14 unused code behaves as NOP
    do_reset();
    issue(3'd6, 3'd0);
    chk(act_ok, 8'hFF, "R14 code 6 leaves banks idle");
    chk(violation, 0, "R14 code 6 no violation");

    // R13 illegal burst length blocks everything
    set_cfg(4'd5, 6'd2, 6'd6, 6'd3, 6'd9);
    do_reset();
    chk(pre_ok, 8'h00, "R13 pre_ok low for BL=5");
    chk(act_ok, 8'h00, "R13 act_ok low for BL=5");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule